// File: doc/BRIEF.md
# Region Write-Lock Unit

This unit guards a 1024-byte storage array against writes into a software-selected region. A 3-bit lock code held inside the unit picks one of several fixed address windows: nothing, the first 16-byte page, the lower quarter, the lower half, the last page, the upper quarter or the upper half. The serial controller in front of the array sends every byte it has received to the unit. Before committing each byte of a page write, it asks the unit whether that byte's 10-bit address may be written. Reads are never gated.

The code changes only through a two-byte lock instruction. The first byte of a selection must be the lock opcode (`8'h83`), and the byte after it carries the new code in its low three bits. The instruction takes effect only when the write-enable latch is set and no programming cycle is running. A timed programming cycle then follows, standing in for nonvolatile storage. The new code appears when that cycle ends, and the unit then asks for the write-enable latch to be cleared. A soft reset leaves the code alone and only a cold reset clears it. The status byte shows the code in bits 2:0 for the read-status path.

Top module: `region_lock_unit`

## Requirements
- R1: After a cold reset the code is 000, `status` reads 8'h00, `busy` is low and no query response is pending.
- R2: `status` always carries the code in bits 2:0, and bits 7:3 read as zero.
- R3: A lock instruction loads bits 2:0 of the code byte as the new code, and bits 7:3 of that byte are ignored. A lock instruction is the opcode 8'h83 as the first byte after `sel` rises, then one further byte while `sel` stays high, with `wel` high and `busy` low when the opcode arrives.
- R4: If `sel` falls after the opcode and before the code byte, the code stays as it was and no programming cycle starts.
- R5: A lock instruction is ignored if `wel` is low, if `busy` is high, or if the opcode is not the first byte of the selection.
- R6: `busy` rises in the cycle after the code byte and stays high for exactly `PROG_CYCLES` cycles. The old code stays visible for that whole time. The new code appears when `busy` falls, together with a one-cycle `wel_clr` pulse.
- R7: A soft reset keeps the current code and abandons a running programming cycle without applying its code.
- R8: Locked windows by code: 000 none; 001 and 111 000h-00Fh; 010 000h-0FFh; 011 000h-1FFh; 100 3F0h-3FFh; 101 300h-3FFh; 110 200h-3FFh.
- R9: A query raised by `wq_vld` is answered one cycle later on `rsp_vld`, with `rsp_ok` low exactly when the queried address lies in the window of the current code.
- R10: Bytes that follow the code byte within the same selection have no effect on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low; clears everything including the code |
| soft_rst_n | input | 1 | Synchronous soft reset, active low; keeps the code |
| sel | input | 1 | High while the device is selected |
| byte_vld | input | 1 | One-cycle strobe marking a fully received byte |
| byte_data | input | 8 | Received byte |
| wel | input | 1 | Current state of the write-enable latch |
| wq_vld | input | 1 | Write-permission query strobe |
| wq_addr | input | 10 | Address of the byte about to be committed |
| rsp_vld | output | 1 | Query answer valid |
| rsp_ok | output | 1 | High if the queried byte may be written |
| status | output | 8 | Status byte: zero bits 7:3 and the code in bits 2:0 |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
Several properties are checked on every cycle. Programming starts only from a fully accepted instruction, and only with the latch set and the unit idle. A fire never happens while deselected. The code moves only at the end of a programming cycle. The clear pulse lasts one cycle. A refusal never comes from code 000. The bench scenarios are the only place the window boundaries are shown. The same holds for the exact length of the busy period, aborted and misplaced instructions, the code surviving a soft reset, and a cold reset wiping it.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
  typedef logic [2:0] lock_code_t;
  typedef enum logic [1:0] {PS_FIRST, PS_ARMED, PS_SKIP} parse_st_t;
  localparam logic [7:0] LOCK_OPCODE = 8'h83;
endpackage

// File: rtl/rlu_cmd_parser.sv
module rlu_cmd_parser
  import rlu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPCODE = LOCK_OPCODE
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              soft_rst_n,
  input  logic              sel,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              wel,
  input  logic              busy,
  output logic              lock_fire
);
  parse_st_t st_q, st_d;
  logic      run_rst;
  logic      opcode_ok;

  assign run_rst   = !cold_rst_n || !soft_rst_n;
  assign opcode_ok = (byte_data == OPCODE) && wel && !busy;
  assign lock_fire = sel && byte_vld && (st_q == PS_ARMED);

  always_comb begin
    st_d = st_q;
    if (!sel) st_d = PS_FIRST;
    else if (byte_vld) begin
      unique case (st_q)
        PS_FIRST: st_d = opcode_ok ? PS_ARMED : PS_SKIP;
        default:  st_d = PS_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (run_rst) st_q <= PS_FIRST;
    else         st_q <= st_d;
  end

  // R5
  armed_needs_permission_chk: assert property (@(posedge clk) disable iff (run_rst)
    (sel && byte_vld && st_q == PS_FIRST && st_d == PS_ARMED) |-> (wel && !busy));
  // R4
  fire_only_selected_chk: assert property (@(posedge clk) disable iff (run_rst)
    lock_fire |-> $past(sel));
endmodule

// File: rtl/rlu_code_store.sv
module rlu_code_store
  import rlu_pkg::*;
#(
  parameter int PROG_CYCLES = 16,
  localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       soft_rst_n,
  input  logic       lock_fire,
  input  lock_code_t new_code,
  output lock_code_t code,
  output logic       busy,
  output logic       wel_clr
);
  lock_code_t       code_q, pend_q;
  logic             busy_q, clr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prog_done;
  logic             run_rst;

  assign run_rst   = !cold_rst_n || !soft_rst_n;
  assign prog_done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!cold_rst_n)   code_q <= '0;
    else if (soft_rst_n && prog_done) code_q <= pend_q;
  end

  always_ff @(posedge clk) begin
    if (run_rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= prog_done;
      if (lock_fire && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        pend_q <= new_code;
      end else if (prog_done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign code    = code_q;
  assign busy    = busy_q;
  assign wel_clr = clr_q;

  // R3
  busy_from_fire_chk: assert property (@(posedge clk) disable iff (run_rst)
    $rose(busy_q) |-> $past(lock_fire));
  // R6
  code_moves_on_done_chk: assert property (@(posedge clk) disable iff (run_rst)
    !prog_done |=> $stable(code_q));
  // R6
  clr_single_pulse_chk: assert property (@(posedge clk) disable iff (run_rst)
    clr_q |=> !clr_q);
endmodule

// File: rtl/rlu_window_dec.sv
module rlu_window_dec
  import rlu_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16
) (
  input  lock_code_t        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int SPAN = 1 << ADDR_W;
  localparam logic [ADDR_W:0] B_PAGE = (ADDR_W+1)'(PAGE_BYTES);
  localparam logic [ADDR_W:0] B_QTR  = (ADDR_W+1)'(SPAN / 4);
  localparam logic [ADDR_W:0] B_HALF = (ADDR_W+1)'(SPAN / 2);
  localparam logic [ADDR_W:0] B_3QTR = (ADDR_W+1)'((SPAN / 4) * 3);
  localparam logic [ADDR_W:0] B_LAST = (ADDR_W+1)'(SPAN - PAGE_BYTES);

  function automatic logic in_window(lock_code_t c, logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] w;
    w = {1'b0, a};
    unique case (c)
      3'd0:    return 1'b0;
      3'd1:    return w < B_PAGE;
      3'd2:    return w < B_QTR;
      3'd3:    return w < B_HALF;
      3'd4:    return w >= B_LAST;
      3'd5:    return w >= B_3QTR;
      3'd6:    return w >= B_HALF;
      default: return w < B_PAGE;
    endcase
  endfunction

  assign locked = in_window(code, addr);
endmodule

// File: rtl/region_lock_unit.sv
module region_lock_unit
  import rlu_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 16,
  parameter int BYTE_W      = 8,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              soft_rst_n,
  input  logic              sel,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              wel,
  input  logic              wq_vld,
  input  logic [ADDR_W-1:0] wq_addr,
  output logic              rsp_vld,
  output logic              rsp_ok,
  output logic [BYTE_W-1:0] status,
  output logic              busy,
  output logic              wel_clr
);
  localparam int CODE_W = $bits(lock_code_t);

  logic       lock_fire;
  logic       busy_w;
  logic       locked_w;
  lock_code_t code_w;
  logic       rsp_vld_q, rsp_ok_q;
  logic       run_rst;

  assign run_rst = !cold_rst_n || !soft_rst_n;

  rlu_cmd_parser #(.BYTE_W(BYTE_W)) u_parser (
    .clk(clk), .cold_rst_n(cold_rst_n), .soft_rst_n(soft_rst_n),
    .sel(sel), .byte_vld(byte_vld), .byte_data(byte_data),
    .wel(wel), .busy(busy_w), .lock_fire(lock_fire)
  );

  rlu_code_store #(.PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .cold_rst_n(cold_rst_n), .soft_rst_n(soft_rst_n),
    .lock_fire(lock_fire), .new_code(byte_data[CODE_W-1:0]),
    .code(code_w), .busy(busy_w), .wel_clr(wel_clr)
  );

  rlu_window_dec #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dec (
    .code(code_w), .addr(wq_addr), .locked(locked_w)
  );

  always_ff @(posedge clk) begin
    if (run_rst) begin
      rsp_vld_q <= 1'b0;
      rsp_ok_q  <= 1'b0;
    end else begin
      rsp_vld_q <= wq_vld;
      rsp_ok_q  <= wq_vld && !locked_w;
    end
  end

  assign rsp_vld = rsp_vld_q;
  assign rsp_ok  = rsp_ok_q;
  assign busy    = busy_w;
  assign status  = {{(BYTE_W-CODE_W){1'b0}}, code_w};

  // R9
  rsp_follows_query_chk: assert property (@(posedge clk) disable iff (run_rst)
    wq_vld |=> rsp_vld);
  // R8
  open_code_never_refuses_chk: assert property (@(posedge clk) disable iff (run_rst)
    (wq_vld && code_w == '0) |=> rsp_ok);
endmodule

// File: tb/region_lock_unit_bench.sv
module region_lock_unit_bench;
  localparam int PROG = 16;
  logic clk = 1'b0;
  logic cold_rst_n = 1'b0, soft_rst_n = 1'b1;
  logic sel = 1'b0, byte_vld = 1'b0, wel = 1'b0, wq_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic [9:0] wq_addr = '0;
  logic rsp_vld, rsp_ok, busy, wel_clr;
  logic [7:0] status;
  int n_vec = 0, n_bad = 0;
  bit exp_q[$];
  bit [9:0] adr_q[$];
  bit [2:0] cur_code = 3'd0;

  always #5 clk = ~clk;

  region_lock_unit #(.PROG_CYCLES(PROG)) u_region_lock_unit (
    .clk(clk), .cold_rst_n(cold_rst_n), .soft_rst_n(soft_rst_n), .sel(sel),
    .byte_vld(byte_vld), .byte_data(byte_data), .wel(wel), .wq_vld(wq_vld),
    .wq_addr(wq_addr), .rsp_vld(rsp_vld), .rsp_ok(rsp_ok), .status(status),
    .busy(busy), .wel_clr(wel_clr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent restatement of the window table (R8)
  function automatic bit writable(bit [2:0] c, bit [9:0] a);
    case (c)
      3'd1, 3'd7: return !(a <= 10'h00F);
      3'd2: return !(a <= 10'h0FF);
      3'd3: return !(a <= 10'h1FF);
      3'd4: return !(a >= 10'h3F0);
      3'd5: return !(a >= 10'h300);
      3'd6: return !(a >= 10'h200);
      default: return 1'b1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rsp_vld) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected response", 1, 0);
      else begin
        bit e; bit [9:0] a;
        e = exp_q.pop_front(); a = adr_q.pop_front();
        check(rsp_ok == e, $sformatf("R8 R9 code=%0d addr=%0h", cur_code, a), rsp_ok, e);
      end
    end
  end

  task automatic query(input bit [9:0] a);
    @(negedge clk);
    wq_vld = 1'b1; wq_addr = a;
    exp_q.push_back(writable(cur_code, a)); adr_q.push_back(a);
    @(negedge clk);
    wq_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input bit [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic frame_start(); @(negedge clk); sel = 1'b1; endtask
  task automatic frame_end();   @(negedge clk); sel = 1'b0; endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * PROG && busy; i++) @(negedge clk);
  endtask

  task automatic sweep();
    bit [9:0] pts[12] = '{10'h000, 10'h00F, 10'h010, 10'h0FF, 10'h100, 10'h1FF,
                          10'h200, 10'h2FF, 10'h300, 10'h3EF, 10'h3F0, 10'h3FF};
    foreach (pts[i]) query(pts[i]);
  endtask

  initial begin
    int cyc;
    bit seen_clr;
    repeat (3) @(negedge clk);
    cold_rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R1 status", status, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rsp_vld == 1'b0, "R1 rsp_vld", rsp_vld, 0);
    sweep();

    // R3 R6: lock code byte F9 -> code 1, busy length and wel_clr pulse
    wel = 1'b1;
    frame_start(); send(8'h83); send(8'hF9);
    cyc = 0; seen_clr = 0;
    check(busy == 1'b1, "R6 busy rises", busy, 1);
    while (busy && cyc < 4 * PROG) begin
      if (status != 8'h00) check(1'b0, "R6 old code during busy", status, 0);
      cyc++; @(negedge clk);
    end
    check(cyc == PROG, "R6 busy length", cyc, PROG);
    check(wel_clr == 1'b1, "R6 wel_clr at end", wel_clr, 1);
    check(status == 8'h01, "R3 R2 new code, high bits ignored", status, 1);
    @(negedge clk);
    check(wel_clr == 1'b0, "R6 wel_clr one cycle", wel_clr, 0);
    frame_end();
    cur_code = 3'd1;
    sweep();

    // R8: every other code
    for (int c = 2; c < 8; c++) begin
      frame_start(); send(8'h83); send(8'(c)); frame_end();
      wait_idle(); @(negedge clk);
      check(status == 8'(c), "R3 code load", status, c);
      cur_code = 3'(c);
      sweep();
    end
    frame_start(); send(8'h83); send(8'h00); frame_end(); wait_idle();
    cur_code = 3'd0; query(10'h000); query(10'h3FF);

    // set code 5 as baseline
    frame_start(); send(8'h83); send(8'h05); frame_end(); wait_idle(); cur_code = 3'd5;

    // R5: latch clear
    wel = 1'b0;
    frame_start(); send(8'h83); send(8'h02); frame_end();
    repeat (PROG + 4) @(negedge clk);
    check(status == 8'h05 && !busy, "R5 wel low ignored", status, 5);
    wel = 1'b1;

    // R4: selection dropped after opcode
    frame_start(); send(8'h83); frame_end();
    frame_start(); send(8'h02); frame_end();
    repeat (PROG + 4) @(negedge clk);
    check(status == 8'h05 && !busy, "R4 abort keeps code", status, 5);

    // R5: opcode not first byte
    frame_start(); send(8'h00); send(8'h83); send(8'h02); frame_end();
    repeat (PROG + 4) @(negedge clk);
    check(status == 8'h05, "R5 opcode not first", status, 5);

    // R5: during busy; R10: trailing byte
    frame_start(); send(8'h83); send(8'h06); send(8'h01); frame_end();
    frame_start(); send(8'h83); send(8'h03); frame_end();
    wait_idle(); repeat (PROG + 4) @(negedge clk);
    check(status == 8'h06, "R5 R10 busy/trailing ignored", status, 6);
    cur_code = 3'd6;
    query(10'h1FF); query(10'h200);

    // R7: soft reset keeps code and cancels pending program
    frame_start(); send(8'h83); send(8'h02); frame_end();
    @(negedge clk); soft_rst_n = 1'b0; @(negedge clk); soft_rst_n = 1'b1;
    check(busy == 1'b0, "R7 busy cleared", busy, 0);
    repeat (PROG + 4) @(negedge clk);
    check(status == 8'h06, "R7 code kept", status, 6);
    query(10'h3FF);

    // R1: cold reset clears code
    @(negedge clk); cold_rst_n = 1'b0; @(negedge clk); cold_rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R1 cold reset clears", status, 0);
    cur_code = 3'd0; query(10'h3FF);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all answered", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule